// File: doc/BRIEF.md
# CAN Fault Confinement Counters

This block keeps the transmit and receive error counts of a CAN node and derives the node's fault confinement state from them: error active, error passive or bus-off. The protocol engine feeds it one-cycle pulses for transmit errors, receive errors and successful frames. On every bus error it also presents an error type and a frame segment code, which the block captures together with the direction of the error.

Software sees the block through a small write port and a set of read words. It can clear both counters at once, program the warning limit, enable three interrupt sources and clear their flags. The read side is made of four parts: a packed counter word, a status word, the interrupt flag word and a single interrupt request line. The status word carries the bus-off bit, the limit-reached bit and the captured error code. Recovery from bus-off beyond clearing the counters belongs to the surrounding controller.

Top module: `can_fault_conf`

## Requirements
- R1: A transmit error pulse adds 8 to the transmit count. A transmit success pulse subtracts 1, and the count never goes below 0. When both pulses arrive in the same cycle, only the error is applied.
- R2: A receive error pulse adds 1 to the receive count and holds it at 255 once it gets there. A receive success pulse subtracts 1, and the count never goes below 0. When both pulses arrive in the same cycle, only the error is applied.
- R3: The counter word shows the transmit count in bits 7:0 and the receive count in bits 23:16. A transmit count above 255 reads as 255 in its field. All other bits of the word read 0.
- R4: A write with select 0 and data equal to zero clears both counts and the captured error code. This clear takes effect over any event in the same cycle. A write with select 0 and nonzero data changes nothing.
- R5: A write with select 1 loads the warning limit from data bits 7:0. After reset the limit is 96. Status bit 6 is 1 when either count is greater than or equal to the limit.
- R6: The node is bus-off when the transmit count exceeds 255. It is error passive when the node is not bus-off and either count exceeds 127. Otherwise it is error active. The state output uses 0 for active, 1 for passive and 2 for bus-off, and status bit 7 mirrors bus-off. While the node is bus-off, the transmit count ignores both error and success pulses.
- R7: On a bus error the status word captures the error type in bits 23:22, the direction in bit 21 and the segment code in bits 20:16. The direction bit is 0 for a transmit error and 1 for a receive error. If both error pulses arrive in the same cycle, the transmit error is the one captured.
- R8: There are three interrupt flags. Bit 7 is set by any bus error. Bit 5 is set when the passive level changes; this level is 1 when either count exceeds 127, and the flag fires on entry and on exit. Bit 2 is set when either the limit-reached level or the bus-off level changes. A flag is set only while its enable bit is 1; enables are written with select 3, using the same bit positions.
- R9: A write with select 2 clears every flag whose data bit is 1. A flag being set in the same cycle wins over the clear. The interrupt request is the OR of the flags. After reset, the counts, the status word, the flags, the enables and the interrupt request are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_err_i | input | 1 | Transmit error pulse |
| rx_err_i | input | 1 | Receive error pulse |
| tx_ok_i | input | 1 | Transmit success pulse |
| rx_ok_i | input | 1 | Receive success pulse |
| err_kind_i | input | 2 | Error type presented with an error pulse |
| err_seg_i | input | 5 | Frame segment code presented with an error pulse |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 2 | Write target: 0 counters, 1 limit, 2 flag clear, 3 enables |
| wr_data_i | input | 32 | Write data |
| cnt_word_o | output | 32 | Packed counter word |
| stat_word_o | output | 32 | Status word with the captured error code |
| flag_word_o | output | 8 | Interrupt flags |
| node_state_o | output | 2 | Fault confinement state |
| irq_o | output | 1 | Interrupt request |

## Verification
A wrong count shows in the counter word on the clock edge right after the faulty event. Because the limit, passive and bus-off thresholds are derived from the same count, the error can also show up later, as a flag that fires early or late, or as the state changing on the wrong event. The bench compares every output on every cycle against a reference model. A divergence is therefore reported in the first cycle it becomes visible, including an interrupt edge that is spurious or missing. Long error bursts push the node into bus-off, and a clear written while it is bus-off checks the return path to the active state.

// File: rtl/can_fc_pkg.sv
package can_fc_pkg;
  typedef enum logic [1:0] {
    FC_ACTIVE  = 2'd0,
    FC_PASSIVE = 2'd1,
    FC_BUSOFF  = 2'd2
  } fc_state_e;

  typedef enum logic [1:0] {
    SEL_COUNTERS = 2'd0,
    SEL_LIMIT    = 2'd1,
    SEL_FLAGCLR  = 2'd2,
    SEL_ENABLE   = 2'd3
  } fc_sel_e;

  localparam int FLAG_BUSERR  = 7;
  localparam int FLAG_PASSIVE = 5;
  localparam int FLAG_WARN    = 2;
endpackage

// File: rtl/can_fc_counters.sv
module can_fc_counters #(
  parameter int TX_W    = 9,
  parameter int RX_W    = 8,
  parameter int LIM_W   = 8,
  parameter int TX_INC  = 8,
  parameter int RX_INC  = 1,
  parameter int PASS_TH = 127,
  parameter int BOFF_TH = 255
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tx_err,
  input  logic             tx_ok,
  input  logic             rx_err,
  input  logic             rx_ok,
  input  logic             clr,
  input  logic [LIM_W-1:0] lim_q,
  input  logic [LIM_W-1:0] lim_nx,
  output logic [TX_W-1:0]  tx_q,
  output logic [RX_W-1:0]  rx_q,
  output logic             warn_q,
  output logic             warn_nx,
  output logic             pas_q,
  output logic             pas_nx,
  output logic             boff_q,
  output logic             boff_nx
);
  localparam int RX_MAX = (1 << RX_W) - 1;

  logic [TX_W-1:0] tx_nx;
  logic [RX_W-1:0] rx_nx;
  logic            upd;

  function automatic logic over_lim(input logic [TX_W-1:0] t,
                                    input logic [RX_W-1:0] r,
                                    input logic [LIM_W-1:0] l);
    return (int'(t) >= int'(l)) || (int'(r) >= int'(l));
  endfunction

  assign boff_q  = int'(tx_q) > BOFF_TH;
  assign boff_nx = int'(tx_nx) > BOFF_TH;
  assign pas_q   = (int'(tx_q) > PASS_TH) || (int'(rx_q) > PASS_TH);
  assign pas_nx  = (int'(tx_nx) > PASS_TH) || (int'(rx_nx) > PASS_TH);
  assign warn_q  = over_lim(tx_q, rx_q, lim_q);
  assign warn_nx = over_lim(tx_nx, rx_nx, lim_nx);
  assign upd     = tx_err | tx_ok | rx_err | rx_ok | clr;

  always_comb begin
    tx_nx = tx_q;
    rx_nx = rx_q;
    if (clr) begin
      tx_nx = '0;
      rx_nx = '0;
    end else begin
      if (!boff_q) begin
        if (tx_err)
          tx_nx = tx_q + TX_W'(TX_INC);
        else if (tx_ok && (tx_q != '0))
          tx_nx = tx_q - 1'b1;
      end
      if (rx_err) begin
        if (int'(rx_q) > RX_MAX - RX_INC)
          rx_nx = RX_W'(RX_MAX);
        else
          rx_nx = rx_q + RX_W'(RX_INC);
      end else if (rx_ok && (rx_q != '0)) begin
        rx_nx = rx_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_q <= '0;
      rx_q <= '0;
    end else if (upd) begin
      tx_q <= tx_nx;
      rx_q <= rx_nx;
    end
  end

  a_r1_tx_add: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_err && !clr && !boff_q) |=> (tx_q == $past(tx_q) + TX_W'(TX_INC)));
  a_r2_rx_floor: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_ok && !rx_err && !clr && (rx_q == '0)) |=> (rx_q == '0));
  a_r6_busoff_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (boff_q && !clr) |=> $stable(tx_q));
  a_r4_clear: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> ((tx_q == '0) && (rx_q == '0)));
endmodule

// File: rtl/can_fc_capture.sv
module can_fc_capture #(
  parameter int KIND_W = 2,
  parameter int SEG_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_err,
  input  logic              rx_err,
  input  logic              clr,
  input  logic [KIND_W-1:0] kind_in,
  input  logic [SEG_W-1:0]  seg_in,
  output logic [KIND_W-1:0] kind_q,
  output logic              dir_q,
  output logic [SEG_W-1:0]  seg_q
);
  logic [KIND_W-1:0] kind_nx;
  logic              dir_nx;
  logic [SEG_W-1:0]  seg_nx;
  logic              cap_en;

  assign cap_en = clr | tx_err | rx_err;

  always_comb begin
    kind_nx = kind_in;
    seg_nx  = seg_in;
    dir_nx  = !tx_err;
    if (clr) begin
      kind_nx = '0;
      seg_nx  = '0;
      dir_nx  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kind_q <= '0;
      dir_q  <= 1'b0;
      seg_q  <= '0;
    end else if (cap_en) begin
      kind_q <= kind_nx;
      dir_q  <= dir_nx;
      seg_q  <= seg_nx;
    end
  end

  a_r7_dir_rx: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_err && !tx_err && !clr) |=> dir_q);
  a_r7_dir_tx: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_err && !clr) |=> !dir_q);
endmodule

// File: rtl/can_fc_irq.sv
module can_fc_irq #(
  parameter int FLAG_W  = 8,
  parameter int BE_BIT  = 7,
  parameter int PAS_BIT = 5,
  parameter int WRN_BIT = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_be,
  input  logic              ev_pas,
  input  logic              ev_wrn,
  input  logic              en_we,
  input  logic              clr_we,
  input  logic [FLAG_W-1:0] wdata,
  output logic [FLAG_W-1:0] flags_q,
  output logic              irq
);
  localparam logic [FLAG_W-1:0] IMPL =
    FLAG_W'((1 << BE_BIT) | (1 << PAS_BIT) | (1 << WRN_BIT));

  logic [FLAG_W-1:0] en_q, en_nx, flags_nx, set_v, clr_v;

  always_comb begin
    set_v = '0;
    set_v[BE_BIT]  = ev_be;
    set_v[PAS_BIT] = ev_pas;
    set_v[WRN_BIT] = ev_wrn;
    set_v    = set_v & en_q;
    clr_v    = clr_we ? (wdata & IMPL) : '0;
    flags_nx = (flags_q & ~clr_v) | set_v;
    en_nx    = en_we ? (wdata & IMPL) : en_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q <= '0;
      en_q    <= '0;
    end else begin
      flags_q <= flags_nx;
      if (en_we) en_q <= en_nx;
    end
  end

  assign irq = |flags_q;

  a_r8_masked_be: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_q[BE_BIT] && !flags_q[BE_BIT]) |=> !flags_q[BE_BIT]);
  a_r9_w1c_pas: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_we && wdata[PAS_BIT] && !(ev_pas && en_q[PAS_BIT])) |=> !flags_q[PAS_BIT]);
  a_r8_only_impl: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(flags_q & ~IMPL) == 0);
endmodule

// File: rtl/can_fault_conf.sv
module can_fault_conf #(
  parameter int TX_W     = 9,
  parameter int RX_W     = 8,
  parameter int LIM_W    = 8,
  parameter int KIND_W   = 2,
  parameter int SEG_W    = 5,
  parameter int WARN_RST = 96
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tx_err_i,
  input  logic        rx_err_i,
  input  logic        tx_ok_i,
  input  logic        rx_ok_i,
  input  logic [1:0]  err_kind_i,
  input  logic [4:0]  err_seg_i,
  input  logic        wr_en_i,
  input  logic [1:0]  wr_sel_i,
  input  logic [31:0] wr_data_i,
  output logic [31:0] cnt_word_o,
  output logic [31:0] stat_word_o,
  output logic [7:0]  flag_word_o,
  output logic [1:0]  node_state_o,
  output logic        irq_o
);
  import can_fc_pkg::*;

  logic [LIM_W-1:0]  lim_q, lim_nx;
  logic              clr, lim_we;
  logic [TX_W-1:0]   tx_q;
  logic [RX_W-1:0]   rx_q;
  logic              warn_q, warn_nx, pas_q, pas_nx, boff_q, boff_nx;
  logic [KIND_W-1:0] kind_q;
  logic              dir_q;
  logic [SEG_W-1:0]  seg_q;
  logic [7:0]        tx_view;
  fc_state_e         st;

  assign clr    = wr_en_i && (wr_sel_i == SEL_COUNTERS) && (wr_data_i == '0);
  assign lim_we = wr_en_i && (wr_sel_i == SEL_LIMIT);
  assign lim_nx = lim_we ? wr_data_i[LIM_W-1:0] : lim_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lim_q <= LIM_W'(WARN_RST);
    else if (lim_we) lim_q <= lim_nx;
  end

  can_fc_counters #(.TX_W(TX_W), .RX_W(RX_W), .LIM_W(LIM_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tx_err(tx_err_i), .tx_ok(tx_ok_i),
    .rx_err(rx_err_i), .rx_ok(rx_ok_i), .clr(clr), .lim_q(lim_q),
    .lim_nx(lim_nx), .tx_q(tx_q), .rx_q(rx_q), .warn_q(warn_q),
    .warn_nx(warn_nx), .pas_q(pas_q), .pas_nx(pas_nx), .boff_q(boff_q),
    .boff_nx(boff_nx)
  );

  can_fc_capture #(.KIND_W(KIND_W), .SEG_W(SEG_W)) u_cap (
    .clk(clk), .rst_n(rst_n), .tx_err(tx_err_i), .rx_err(rx_err_i),
    .clr(clr), .kind_in(err_kind_i), .seg_in(err_seg_i),
    .kind_q(kind_q), .dir_q(dir_q), .seg_q(seg_q)
  );

  can_fc_irq #(.FLAG_W(8), .BE_BIT(FLAG_BUSERR), .PAS_BIT(FLAG_PASSIVE),
               .WRN_BIT(FLAG_WARN)) u_irq (
    .clk(clk), .rst_n(rst_n),
    .ev_be(tx_err_i | rx_err_i),
    .ev_pas(pas_q != pas_nx),
    .ev_wrn((warn_q != warn_nx) || (boff_q != boff_nx)),
    .en_we(wr_en_i && (wr_sel_i == SEL_ENABLE)),
    .clr_we(wr_en_i && (wr_sel_i == SEL_FLAGCLR)),
    .wdata(wr_data_i[7:0]),
    .flags_q(flag_word_o), .irq(irq_o)
  );

  always_comb begin
    tx_view = (int'(tx_q) > 255) ? 8'hFF : tx_q[7:0];
    if (boff_q)     st = FC_BUSOFF;
    else if (pas_q) st = FC_PASSIVE;
    else            st = FC_ACTIVE;
  end

  assign cnt_word_o   = {8'h00, 8'(rx_q), 8'h00, tx_view};
  assign stat_word_o  = {8'h00, kind_q, dir_q, seg_q, 8'h00, boff_q, warn_q, 6'b0};
  assign node_state_o = st;

  a_r6_state_legal: assert property (@(posedge clk) disable iff (!rst_n)
    node_state_o != 2'd3);
  a_r5_limit_load: assert property (@(posedge clk) disable iff (!rst_n)
    lim_we |=> (lim_q == $past(wr_data_i[LIM_W-1:0])));
endmodule

// File: tb/can_fault_conf_test.sv
module can_fault_conf_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tx_err_i = 0, rx_err_i = 0, tx_ok_i = 0, rx_ok_i = 0;
  logic [1:0] err_kind_i = 0;
  logic [4:0] err_seg_i = 0;
  logic wr_en_i = 0;
  logic [1:0] wr_sel_i = 0;
  logic [31:0] wr_data_i = 0;
  logic [31:0] cnt_word_o, stat_word_o;
  logic [7:0] flag_word_o;
  logic [1:0] node_state_o;
  logic irq_o;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  int m_tx, m_rx, m_lim, m_kind, m_dir, m_seg;
  logic [7:0] m_en, m_flags;

  always #10 clk = ~clk;

  can_fault_conf uut (.*);

  function automatic bit f_warn(int t, int r, int l);
    return (t >= l) || (r >= l);
  endfunction
  function automatic bit f_pas(int t, int r);
    return (t > 127) || (r > 127);
  endfunction
  function automatic int f_state(int t, int r);
    if (t > 255) return 2;
    if (f_pas(t, r)) return 1;
    return 0;
  endfunction

  task automatic chk(string req, string what, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    chk("R1", "tx field", int'(cnt_word_o[7:0]), (m_tx > 255) ? 255 : m_tx);
    chk("R2", "rx field", int'(cnt_word_o[23:16]), m_rx);
    chk("R3", "counter spare bits", int'({cnt_word_o[31:24], cnt_word_o[15:8]}), 0);
    chk("R5", "limit bit", int'(stat_word_o[6]), int'(f_warn(m_tx, m_rx, m_lim)));
    chk("R6", "busoff bit", int'(stat_word_o[7]), int'(m_tx > 255));
    chk("R6", "state", int'(node_state_o), f_state(m_tx, m_rx));
    chk("R7", "capture", int'(stat_word_o[23:16]), (m_kind << 6) | (m_dir << 5) | m_seg);
    chk("R8", "flags", int'(flag_word_o), int'(m_flags));
    chk("R9", "irq", int'(irq_o), int'(m_flags != 0));
  endtask

  task automatic step(bit te, bit re, bit to, bit ro, int kind, int seg,
                      bit w, int sel, logic [31:0] d);
    bit clr, be, pe, we, wo, wn, po, pn, bo, bn;
    int ntx, nrx, nlim;
    logic [7:0] setv, clrv;
    @(negedge clk);
    compare_all();
    tx_err_i = te; rx_err_i = re; tx_ok_i = to; rx_ok_i = ro;
    err_kind_i = 2'(kind); err_seg_i = 5'(seg);
    wr_en_i = w; wr_sel_i = 2'(sel); wr_data_i = d;
    clr = w && sel == 0 && d == 0;
    ntx = m_tx; nrx = m_rx;
    if (m_tx <= 255) begin
      if (te) ntx = m_tx + 8;
      else if (to && m_tx > 0) ntx = m_tx - 1;
    end
    if (re) nrx = (m_rx == 255) ? 255 : m_rx + 1;
    else if (ro && m_rx > 0) nrx = m_rx - 1;
    if (clr) begin ntx = 0; nrx = 0; end
    nlim = (w && sel == 1) ? int'(d[7:0]) : m_lim;
    wo = f_warn(m_tx, m_rx, m_lim); wn = f_warn(ntx, nrx, nlim);
    po = f_pas(m_tx, m_rx); pn = f_pas(ntx, nrx);
    bo = m_tx > 255; bn = ntx > 255;
    be = te || re; pe = po != pn; we = (wo != wn) || (bo != bn);
    setv = {be, 1'b0, pe, 2'b00, we, 2'b00} & m_en;
    clrv = (w && sel == 2) ? (d[7:0] & 8'hA4) : 8'h00;
    m_flags = (m_flags & ~clrv) | setv;
    if (w && sel == 3) m_en = d[7:0] & 8'hA4;
    if (clr) begin m_kind = 0; m_dir = 0; m_seg = 0; end
    else if (te) begin m_kind = kind; m_dir = 0; m_seg = seg; end
    else if (re) begin m_kind = kind; m_dir = 1; m_seg = seg; end
    m_tx = ntx; m_rx = nrx; m_lim = nlim;
  endtask

  task automatic idle();
    step(0, 0, 0, 0, 0, 0, 0, 0, 32'h0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'h5EED_C0DE));
    m_tx = 0; m_rx = 0; m_lim = 96; m_kind = 0; m_dir = 0; m_seg = 0;
    m_en = 0; m_flags = 0;
    repeat (3) @(negedge clk);
    // R9: reset state
    chk("R9", "reset cnt", int'(cnt_word_o), 0);
    chk("R9", "reset stat", int'(stat_word_o), 0);
    chk("R9", "reset flags", int'(flag_word_o), 0);
    rst_n = 1'b1;
    idle();
    step(0, 0, 0, 0, 0, 0, 1, 3, 32'hFF);          // enable all flags
    // R1/R6: drive to bus-off with 32 transmit errors
    for (int i = 0; i < 32; i++) step(1, 0, 0, 0, i % 4, i % 32, 0, 0, 0);
    idle();
    chk("R6", "busoff reached", int'(node_state_o), 2);
    step(1, 0, 0, 0, 1, 3, 0, 0, 0);
    step(0, 0, 1, 0, 0, 0, 0, 0, 0);
    idle();
    chk("R6", "tx frozen in busoff", int'(node_state_o), 2);
    // R4: nonzero write ignored, zero write clears
    step(0, 0, 0, 0, 0, 0, 1, 0, 32'h0000_0100);
    idle();
    chk("R4", "nonzero write ignored", int'(cnt_word_o[7:0]), 255);
    step(1, 1, 0, 0, 2, 9, 1, 0, 32'h0);
    idle();
    chk("R4", "clear cnt", int'(cnt_word_o), 0);
    chk("R4", "clear capture", int'(stat_word_o[23:16]), 0);
    // R1: error beats success in the same cycle
    step(1, 0, 1, 0, 3, 17, 0, 0, 0);
    idle();
    chk("R1", "err over ok", int'(cnt_word_o[7:0]), 8);
    // R7: receive error captures direction 1
    step(0, 1, 0, 0, 1, 22, 0, 0, 0);
    idle();
    chk("R7", "rx capture", int'(stat_word_o[23:16]), (1 << 6) | (1 << 5) | 22);
    // R5: limit lowered to 1 sets limit bit
    step(0, 0, 0, 0, 0, 0, 1, 1, 32'h1);
    idle();
    chk("R5", "limit bit low", int'(stat_word_o[6]), 1);
    // R9: write-one-to-clear
    step(0, 0, 0, 0, 0, 0, 1, 2, 32'hFF);
    idle();
    chk("R9", "w1c", int'(flag_word_o), 0);
    // R2: receive saturation
    for (int i = 0; i < 260; i++) step(0, 1, 0, 0, 0, 1, 0, 0, 0);
    idle();
    chk("R2", "rx saturate", int'(cnt_word_o[23:16]), 255);
    step(0, 0, 0, 0, 0, 0, 1, 0, 32'h0);
    // random phase
    for (int i = 0; i < 6000; i++) begin
      int p, hi;
      bit te, re, to, ro, w;
      int sel;
      logic [31:0] d;
      hi = ((i / 1000) % 2 == 0) ? 30 : 8;
      p = $urandom_range(0, 99); te = p < hi;
      p = $urandom_range(0, 99); re = p < hi;
      p = $urandom_range(0, 99); to = p < 40;
      p = $urandom_range(0, 99); ro = p < 40;
      w = $urandom_range(0, 99) < 4;
      sel = $urandom_range(0, 3);
      d = $urandom();
      if (sel == 0 && $urandom_range(0, 3) == 0) d = 0;
      step(te, re, to, ro, $urandom_range(0, 3), $urandom_range(0, 31), w, sel, d);
    end
    idle();
    @(negedge clk);
    compare_all();
    finish_run();
  end
endmodule